// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Multiprocessor Framing

This block is a full-duplex asynchronous serial port. Software sets it up through an 8-bit control field in the upper half of a 16-bit register and moves bytes through a transmit buffer and a receive holding register. Frame timing comes from an external tick at sixteen times the bit rate. Framing can be configured in several ways: 7 or 8 data bits, optional even or odd parity, and one or two stop bits on transmit. A multiprocessor mode adds a ninth bit that marks a frame as an address or as data.

An operating-mode input selects one of three modes. In mode 0 the port runs normal asynchronous framing. In mode 1 every frame carries the address/data marker bit. Mode 2 is the synchronous mode, and here the block only applies its register constraints: 8 data bits and no parity. Both directions complete the frame they are working on when their enable is withdrawn. Receive errors are sticky until software writes a zero to the error-clear bit.

Top module: `serial_port_ctl`

## Requirements
- R1: The control field sits in bits 15..8 of address 0. From bit 15 down, the bits are: parity enable, parity select, two-stop select, 8-bit select, address marker, error-clear (active low), receive enable, transmit enable. A read of address 0 returns the stored field with bit 10 always 1 and bits 7..0 zero. The value after reset is 0x0400.
- R2: TXD idles high. A frame is a 0 start bit followed by the data bits, least significant bit first, then an optional extra bit, then the stop bits (1).
- R3: When parity is enabled in mode 0, a parity bit follows the data. With select = 0 the parity is even; with select = 1 it is odd. A received parity bit that does not match sets the parity error flag, and the data is still stored.
- R4: On transmit, the two-stop select sends two stop bits instead of one. On receive, only the first stop bit is sampled. A 0 there sets the framing error flag.
- R5: The 8-bit select chooses 8 or 7 data bits in mode 0. In modes 1 and 2 the port always uses 8 bits and no parity. A 7-bit receive reads back with bit 7 = 0.
- R6: In mode 1 the extra bit after the data is the address marker on transmit. On receive, that bit is shown on `rx_addr_bit`.
- R7: A write to address 0 with bit 10 = 0 clears the framing, overrun and parity flags. A write with bit 10 = 1 leaves them unchanged.
- R8: A frame whose start bit was accepted is received and stored even if receive enable is cleared partway through. A frame that begins while receive is disabled is ignored.
- R9: Clearing transmit enable does not cut short a frame in progress. A byte written while transmit is disabled stays buffered, and TXD stays idle, until transmit is enabled again.
- R10: The receiver samples its start bit at half a bit time. If the line is high again by then, the start is rejected and nothing is stored.
- R11: If a frame completes while the previous byte is still unread, the overrun flag is set and the old byte is kept.
- R12: A read of address 1 returns the received byte and clears `rx_full`. `rx_irq` is high whenever `rx_full` or any error flag is set. Address 2 reads the flags {parity, overrun, framing, rx_full, tx_empty, addr} in bits 7..2.
- R13: `tx_empty` is 1 after reset. It drops when a byte is written to address 1 and returns to 1 once the shifter takes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 transmit data) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address (0 control, 1 receive data, 2 flags) |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| op_mode | input | 2 | Operating mode 0, 1 or 2 |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_full | output | 1 | Received byte waiting |
| tx_empty | output | 1 | Transmit buffer free |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| err_parity | output | 1 | Parity error flag |
| rx_addr_bit | output | 1 | Marker bit of last stored mode 1 frame |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Several properties are checked on every cycle:
- TXD stays high while the shifter is idle.
- A shift in progress ends only on a tick.
- A receive frame already in its data phase survives a cleared enable.
- An overrun leaves the stored byte unchanged.
- An error-clear write empties the error flags.
- A data write marks the buffer occupied.

The bench scenarios are needed for the bit-exact frame layouts under each mode and format, parity polarity, sampling of only the first stop bit, rejection of a glitch on the start bit, and the deferred transmit after re-enabling. Each of these depends on a whole sequence of serial bits.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
    logic len8;
    logic adr_mark;
    logic clr_n;
    logic rx_en;
    logic tx_en;
  } sp_ctrl_t;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
    logic len8;
    logic mp;
  } sp_fmt_t;

  // Apply the mode constraints: parity only in mode 0, 8 bits outside mode 0.
  function automatic sp_fmt_t sp_effective(sp_ctrl_t c, logic [1:0] mode);
    sp_fmt_t f;
    f.par_en  = c.par_en && (mode == 2'd0);
    f.par_odd = c.par_odd;
    f.stop2   = c.stop2;
    f.len8    = c.len8 || (mode != 2'd0);
    f.mp      = (mode == 2'd1);
    return f;
  endfunction

endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import serial_port_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FRAME_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       start,
  input  sp_fmt_t    fmt,
  input  logic       adr_mark,
  input  logic [7:0] data,
  output logic       busy,
  output logic       txd
);
  localparam int CW = $clog2(OVS);
  localparam int LW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_c, shreg;
  logic [LW-1:0]      len_c, left;
  logic [CW-1:0]      tcnt;
  logic               has_x, par, xbit;

  always_comb begin
    has_x   = fmt.mp || fmt.par_en;
    par     = fmt.len8 ? ^data : ^data[6:0];
    xbit    = fmt.mp ? adr_mark : (par ^ fmt.par_odd);
    frame_c = '1;
    frame_c[0] = 1'b0;
    if (fmt.len8) begin
      frame_c[8:1] = data;
      frame_c[9]   = has_x ? xbit : 1'b1;
    end else begin
      frame_c[7:1] = data[6:0];
      frame_c[8]   = has_x ? xbit : 1'b1;
    end
    len_c = LW'(1) + (fmt.len8 ? LW'(8) : LW'(7)) + LW'(has_x)
          + (fmt.stop2 ? LW'(2) : LW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        shreg <= frame_c;
        left  <= len_c;
        tcnt  <= '0;
        busy  <= 1'b1;
        txd   <= frame_c[0];
      end else begin
        txd <= 1'b1;
      end
    end else if (baud_tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - LW'(1);
        if (left == LW'(1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd <= shreg[1];
        end
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  // R2
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> txd);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !baud_tick) |=> busy);

endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       len8,
  input  logic       mp,
  output logic       done,
  output logic [7:0] d_out,
  output logic       addr_out,
  output logic       par_bad,
  output logic       stop_bad
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;
  rx_st_t     st;
  logic [1:0] sync;
  logic       rxs, armed;
  logic [CW-1:0] cnt;
  logic [3:0] idx, nsamp;
  logic [8:0] bits_q;
  logic       l_pen, l_odd, l_len8, l_mp;
  logic [7:0] dat_c;
  logic       xb_c;

  assign rxs = sync[1];

  always_comb begin
    nsamp = (l_len8 ? 4'd8 : 4'd7) + {3'b0, (l_pen || l_mp)} + 4'd1;
    dat_c = l_len8 ? bits_q[7:0] : {1'b0, bits_q[6:0]};
    xb_c  = l_len8 ? bits_q[8] : bits_q[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      st <= RX_IDLE; armed <= 1'b0; cnt <= '0; idx <= '0; bits_q <= '0;
      l_pen <= 1'b0; l_odd <= 1'b0; l_len8 <= 1'b1; l_mp <= 1'b0;
      done <= 1'b0; d_out <= '0; addr_out <= 1'b0;
      par_bad <= 1'b0; stop_bad <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      case (st)
        RX_IDLE: if (baud_tick) begin
          if (rxs) armed <= 1'b1;
          else if (armed && rx_en) begin
            st <= RX_START; armed <= 1'b0; cnt <= '0;
            l_pen <= par_en; l_odd <= par_odd; l_len8 <= len8; l_mp <= mp;
          end
        end
        RX_START: if (baud_tick) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            st  <= rxs ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + CW'(1);
        end
        RX_BITS: if (baud_tick) begin
          if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            if (idx == nsamp - 4'd1) begin
              done     <= 1'b1;
              st       <= RX_IDLE;
              d_out    <= dat_c;
              addr_out <= l_mp && xb_c;
              par_bad  <= l_pen && ((^dat_c ^ xb_c) != l_odd);
              stop_bad <= !rxs;
            end else begin
              bits_q[idx] <= rxs;
              idx <= idx + 4'd1;
            end
          end else cnt <= cnt + CW'(1);
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8
  rx_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_BITS && !rx_en) |=> (st == RX_BITS || done));
  // R10
  rx_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == RX_BITS);

endmodule

// File: rtl/serial_port_ctl.sv
module serial_port_ctl
  import serial_port_pkg::*;
#(
  parameter int OVS = 16,
  parameter int AW  = 2,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    op_mode,
  input  logic          baud_tick,
  input  logic          rxd,
  output logic          txd,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          err_frame,
  output logic          err_overrun,
  output logic          err_parity,
  output logic          rx_addr_bit,
  output logic          rx_irq
);
  localparam int CLSB = DW - 8;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DATA = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  sp_ctrl_t   ctl_q;
  sp_fmt_t    fmt;
  logic [7:0] tx_buf, rx_data_q;
  logic       tx_full, tx_busy, tx_start;
  logic       wr_ctl, wr_dat, rd_hit, clr;
  logic       rx_done, rx_pbad, rx_sbad, rx_addr;
  logic [7:0] rx_byte;

  always_comb begin
    fmt      = sp_effective(ctl_q, op_mode);
    wr_ctl   = wr_en && (wr_addr == A_CTRL);
    wr_dat   = wr_en && (wr_addr == A_DATA);
    rd_hit   = rd_en && (rd_addr == A_DATA);
    clr      = wr_ctl && !wr_data[CLSB+2];
    tx_start = tx_full && ctl_q.tx_en && !tx_busy;
    tx_empty = !tx_full;
    rx_irq   = rx_full || err_frame || err_overrun || err_parity;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= sp_ctrl_t'(8'h04);
      tx_buf  <= '0;
      tx_full <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q       <= sp_ctrl_t'(wr_data[DW-1:CLSB]);
        ctl_q.clr_n <= 1'b1;
      end
      if (tx_start) tx_full <= 1'b0;
      if (wr_dat) begin
        tx_buf  <= wr_data[7:0];
        tx_full <= 1'b1;
      end
      if (rd_en) begin
        case (rd_addr)
          A_CTRL:  rd_data <= {ctl_q, {CLSB{1'b0}}};
          A_DATA:  rd_data <= {{CLSB{1'b0}}, rx_data_q};
          A_STAT:  rd_data <= {{CLSB{1'b0}}, err_parity, err_overrun, err_frame,
                               rx_full, tx_empty, rx_addr_bit, 2'b00};
          default: rd_data <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_q <= '0; rx_full <= 1'b0; rx_addr_bit <= 1'b0;
      err_frame <= 1'b0; err_overrun <= 1'b0; err_parity <= 1'b0;
    end else begin
      if (clr) begin
        err_frame <= 1'b0; err_overrun <= 1'b0; err_parity <= 1'b0;
      end
      if (rd_hit) rx_full <= 1'b0;
      if (rx_done) begin
        if (rx_full && !rd_hit) err_overrun <= 1'b1;
        else begin
          rx_data_q   <= rx_byte;
          rx_full     <= 1'b1;
          rx_addr_bit <= rx_addr;
          if (rx_sbad) err_frame  <= 1'b1;
          if (rx_pbad) err_parity <= 1'b1;
        end
      end
    end
  end

  sp_tx #(.OVS(OVS), .FRAME_W(12)) u_tx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .start(tx_start), .fmt(fmt),
    .adr_mark(ctl_q.adr_mark), .data(tx_buf), .busy(tx_busy), .txd(txd)
  );

  sp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd), .rx_en(ctl_q.rx_en),
    .par_en(fmt.par_en), .par_odd(fmt.par_odd), .len8(fmt.len8), .mp(fmt.mp),
    .done(rx_done), .d_out(rx_byte), .addr_out(rx_addr),
    .par_bad(rx_pbad), .stop_bad(rx_sbad)
  );

  // R11
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !rd_hit) |=> (err_overrun && $stable(rx_data_q)));
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !rx_done) |=> !(err_frame || err_overrun || err_parity));
  // R13
  tx_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> !tx_empty);

endmodule

// File: tb/serial_port_ctl_tb.sv
module serial_port_ctl_tb;
  localparam int CLK_P = 10;
  localparam int OVS   = 16;
  localparam int BITC  = OVS * 2;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, baud_tick = 0, rxd = 1;
  logic [1:0] wr_addr = 0, rd_addr = 0, op_mode = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic txd, rx_full, tx_empty, err_frame, err_overrun, err_parity, rx_addr_bit, rx_irq;

  int checks = 0, errs = 0, tx_frames = 0;
  bit finished = 0;
  logic [7:0] cur_ctl = 8'h04;
  logic [15:0] exp_f[$];
  int exp_n[$];

  serial_port_ctl #(.OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .op_mode(op_mode),
    .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .rx_full(rx_full),
    .tx_empty(tx_empty), .err_frame(err_frame), .err_overrun(err_overrun),
    .err_parity(err_parity), .rx_addr_bit(rx_addr_bit), .rx_irq(rx_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    baud_tick = ~baud_tick;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // behavioural frame model
  function automatic void mk(input logic [7:0] d, input logic [7:0] c, input logic [1:0] md,
                             output logic [15:0] f, output int n);
    bit l8 = c[4] || (md != 0);
    bit pe = c[7] && (md == 0);
    f = '1; f[0] = 1'b0; n = 1;
    for (int k = 0; k < (l8 ? 8 : 7); k++) begin f[n] = d[k]; n++; end
    if (md == 1) begin f[n] = c[3]; n++; end
    else if (pe) begin f[n] = (l8 ? ^d : ^d[6:0]) ^ c[6]; n++; end
    f[n] = 1'b1; n++;
    if (c[5]) begin f[n] = 1'b1; n++; end
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic set_ctl(input logic [7:0] c);
    cur_ctl = c | 8'h04;
    wr(0, {c, 8'h00});
  endtask

  task automatic tx_send(input logic [7:0] d);
    logic [15:0] f; int n;
    mk(d, cur_ctl, op_mode, f, n);
    exp_f.push_back(f); exp_n.push_back(n);
    wr(1, {8'h00, d});
  endtask

  task automatic rx_send(input logic [7:0] d, input logic [7:0] c, input logic [15:0] flip);
    logic [15:0] f; int n;
    mk(d, c, op_mode, f, n);
    f = f ^ flip;
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1;
  endtask

  task automatic wait_tx(input int cnt);
    while (tx_frames < cnt) @(negedge clk);
    repeat (BITC) @(negedge clk);
  endtask

  // transmit monitor against the expected-frame queue (R2..R6, R9)
  initial forever begin
    logic [15:0] f, got, m; int n;
    @(negedge txd);
    repeat (BITC/2) @(negedge clk);
    if (exp_n.size() == 0) begin
      chk(0, "R9 unexpected tx frame", 0, 1);
    end else begin
      f = exp_f.pop_front(); n = exp_n.pop_front(); got = '1;
      for (int i = 0; i < n; i++) begin
        got[i] = txd;
        if (i < n - 1) repeat (BITC) @(negedge clk);
      end
      m = 16'((32'h1 << n) - 1);
      chk((got & m) == (f & m), "R2 tx frame bits", int'(got & m), int'(f & m));
    end
    tx_frames++;
  end

  // interrupt relation every clock (R12)
  initial forever begin
    @(negedge clk);
    if (!rst)
      chk(rx_irq == (rx_full | err_frame | err_overrun | err_parity), "R12 rx_irq",
          rx_irq, rx_full | err_frame | err_overrun | err_parity);
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int seen;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(txd == 1, "R2 idle txd", txd, 1);
    chk(tx_empty == 1, "R13 reset tx_empty", tx_empty, 1);
    chk({rx_full, err_frame, err_overrun, err_parity} == 0, "R12 reset flags",
        {rx_full, err_frame, err_overrun, err_parity}, 0);
    rd(0, v); chk(v == 16'h0400, "R1 reset ctrl", v, 16'h0400);
    wr(0, 16'hAB00);
    rd(0, v); chk(v == 16'hAF00, "R1 ctrl readback", v, 16'hAF00);

    // transmit formats
    set_ctl(8'h17); tx_send(8'hA5); wait_tx(1);
    set_ctl(8'h97); tx_send(8'h07); wait_tx(2);           // R3 even
    set_ctl(8'hD7); tx_send(8'h07); wait_tx(3);           // R3 odd
    set_ctl(8'h27); tx_send(8'hC3); wait_tx(4);           // R4 R5 7 bits 2 stop
    op_mode = 1;
    set_ctl(8'h8F); tx_send(8'h81); wait_tx(5);           // R6 marker 1, parity ignored
    set_ctl(8'h87); tx_send(8'h3E); wait_tx(6);           // R6 marker 0
    op_mode = 0;

    // R9 transmit disable mid-frame
    set_ctl(8'h17); tx_send(8'h3C);
    while (txd != 0) @(negedge clk);
    repeat (2*BITC) @(negedge clk);
    set_ctl(8'h16);
    wait_tx(7);
    wr(1, 16'h0099);
    seen = tx_frames;
    repeat (14*BITC) @(negedge clk);
    chk(tx_empty == 0, "R9 byte held while disabled", tx_empty, 0);
    chk(tx_frames == seen && txd == 1, "R9 no frame while disabled", tx_frames, seen);
    begin logic [15:0] f; int n; mk(8'h99, 8'h17, 0, f, n); exp_f.push_back(f); exp_n.push_back(n); end
    set_ctl(8'h17);
    wait_tx(8);
    chk(tx_empty == 1, "R13 tx_empty after send", tx_empty, 1);

    // receive 8N1
    rx_send(8'h5A, 8'h17, 0);
    repeat (8) @(negedge clk);
    chk(rx_full == 1 && err_frame == 0 && err_parity == 0, "R12 rx_full set", rx_full, 1);
    rd(1, v); chk(v == 16'h005A, "R2 rx data", v, 16'h005A);
    chk(rx_full == 0, "R12 read clears rx_full", rx_full, 0);

    // R3 parity error, R7 clear
    set_ctl(8'h97);
    rx_send(8'h07, 8'h97, 16'h0200);
    repeat (8) @(negedge clk);
    chk(err_parity == 1, "R3 parity error", err_parity, 1);
    rd(1, v); chk(v == 16'h0007, "R3 data kept on parity error", v, 16'h0007);
    set_ctl(8'h97);
    chk(err_parity == 1, "R7 write one no effect", err_parity, 1);
    wr(0, 16'h9300); cur_ctl = 8'h97;
    chk(err_parity == 0, "R7 clear parity", err_parity, 0);
    set_ctl(8'hD7);
    rx_send(8'h07, 8'hD7, 0);
    repeat (8) @(negedge clk);
    chk(err_parity == 0, "R3 odd parity ok", err_parity, 0);
    rd(1, v);

    // R4 framing error
    set_ctl(8'h17);
    rx_send(8'h11, 8'h17, 16'h0200);
    repeat (8) @(negedge clk);
    chk(err_frame == 1, "R4 framing error", err_frame, 1);
    rd(1, v);
    wr(0, 16'h1300);
    chk(err_frame == 0, "R7 clear framing", err_frame, 0);
    repeat (BITC) @(negedge clk);

    // R4 only first stop sampled
    set_ctl(8'h37);
    fork
      begin rx_send(8'h21, 8'h17, 0); rx_send(8'h42, 8'h17, 0); end
      begin
        while (!rx_full) @(negedge clk);
        rd(1, v); chk(v == 16'h0021, "R4 first of back-to-back", v, 16'h0021);
        chk(err_frame == 0, "R4 single stop accepted", err_frame, 1'b0);
      end
    join
    repeat (8) @(negedge clk);
    rd(1, v); chk(v == 16'h0042, "R4 second of back-to-back", v, 16'h0042);
    chk(err_frame == 0, "R4 no framing error", err_frame, 0);

    // R11 overrun
    set_ctl(8'h17);
    rx_send(8'h11, 8'h17, 0);
    rx_send(8'h22, 8'h17, 0);
    repeat (8) @(negedge clk);
    chk(err_overrun == 1, "R11 overrun flag", err_overrun, 1);
    rd(1, v); chk(v == 16'h0011, "R11 old byte kept", v, 16'h0011);
    wr(0, 16'h1300);
    chk(err_overrun == 0, "R7 clear overrun", err_overrun, 0);

    // R5 seven-bit receive
    set_ctl(8'h07);
    rx_send(8'hBB, 8'h07, 0);
    repeat (8) @(negedge clk);
    rd(1, v); chk(v == 16'h003B, "R5 seven-bit data", v, 16'h003B);

    // R5 R6 mode 1 receive
    op_mode = 1;
    set_ctl(8'h87);
    rx_send(8'hF0, 8'h8F, 0);
    repeat (8) @(negedge clk);
    chk(rx_addr_bit == 1, "R6 address frame", rx_addr_bit, 1);
    chk(err_parity == 0, "R5 no parity in mode 1", err_parity, 0);
    rd(1, v); chk(v == 16'h00F0, "R5 mode 1 eight bits", v, 16'h00F0);
    rx_send(8'h0F, 8'h87, 0);
    repeat (8) @(negedge clk);
    chk(rx_addr_bit == 0, "R6 data frame", rx_addr_bit, 0);
    rd(1, v);
    op_mode = 0;

    // R8 receive disable mid-frame
    set_ctl(8'h17);
    fork
      rx_send(8'h6E, 8'h17, 0);
      begin repeat (3*BITC) @(negedge clk); set_ctl(8'h15); end
    join
    repeat (8) @(negedge clk);
    chk(rx_full == 1, "R8 frame completed after disable", rx_full, 1);
    rd(1, v); chk(v == 16'h006E, "R8 data stored", v, 16'h006E);
    rx_send(8'h77, 8'h17, 0);
    repeat (8) @(negedge clk);
    chk(rx_full == 0, "R8 ignored while disabled", rx_full, 0);

    // R10 false start
    set_ctl(8'h17);
    repeat (BITC) @(negedge clk);
    rxd = 0; repeat (6) @(negedge clk); rxd = 1;
    repeat (3*BITC) @(negedge clk);
    chk(rx_full == 0 && err_frame == 0, "R10 glitch rejected", rx_full, 0);
    rx_send(8'h0F, 8'h17, 0);
    repeat (8) @(negedge clk);
    rd(1, v); chk(v == 16'h000F, "R10 recovery", v, 16'h000F);

    chk(exp_n.size() == 0, "R2 all frames sent", exp_n.size(), 0);
    finish_run();
  end

endmodule